// File: doc/BRIEF.md
# Serial EEPROM Host Command Sequencer

This block sits on the host side of a three-wire serial EEPROM link. A single-cycle request names an operation, a word address and, for writes, a 16-bit data word. The sequencer builds the serial frame, drives chip select, the serial clock and the data line from the fast system clock, and shifts in the data-out line. It returns the read word together with a one-cycle completion pulse.

Each frame can be padded with leading zero clocks so that its command part fills exactly one 16-clock unit. The sequencer keeps three timing minimums, each a parameter counted in system clocks: the width of each serial clock phase, the time chip select is high before the first rising clock edge, and the time chip select stays low between frames. After a programming operation it polls the memory. It drops chip select, raises it again and reads the data-out line. It finishes when the line reads 1, or it reports a timeout after a set number of polls.

Top module: `eeprom_cmd_seq`

## Requirements
- R1: A frame is sent MSB first in this order: the pad zeros, a start bit of 1, a 2-bit opcode, an ADDR_W-bit address field, and then for a data-carrying operation 16 data bits. The `req_op` codes are: 0 = read (opcode 10, address), 1 = write (01, address, data), 2 = erase (11, address), 3 = write-all (00, field 01 then zeros, data), 4 = erase-all (00, field 10 then zeros), 5 = write-enable (00, field 11 then zeros), 6 = write-disable (00, field 00 then zeros).
- R2: With PAD_EN=1 the number of pad zeros is (16 - (3+ADDR_W) mod 16) mod 16, which is 7 for ADDR_W=6. With PAD_EN=0 no pad is sent.
- R3: `mem_sk` is high only while `mem_cs` is high. Each high phase and each low phase between rising edges lasts exactly HALF_CYC system cycles. `mem_di` changes only while `mem_sk` is low.
- R4: `mem_cs` is high for at least SETUP_CYC system cycles before the first rising edge of `mem_sk` in a frame.
- R5: `mem_cs` stays low for at least DESEL_CYC system cycles between any two high periods, poll periods included.
- R6: A read sends 16 extra clocks with `mem_di` low. It samples `mem_do` in the last system cycle of each of their low phases and shifts the bits in MSB first. `rd_data` holds the word when `done` pulses.
- R7: `busy` is high from the cycle after a request is accepted until `done`. `done` is a one-cycle pulse, given after `mem_cs` has gone low and DESEL_CYC has elapsed. `req_valid` is ignored while `busy` is high.
- R8: After a write, erase, write-all or erase-all, the block repeats a poll: `mem_cs` low for DESEL_CYC, then high for SETUP_CYC with no clocks, with `mem_do` sampled in the last cycle. The first poll that reads 1 ends the operation with `timed_out`=0.
- R9: If POLL_LIMIT polls in a row read 0, the operation ends with `timed_out`=1 after exactly POLL_LIMIT polls.
- R10: Read, write-enable and write-disable do no polling and end with `timed_out`=0.
- R11: While reset is held, `mem_cs`, `mem_sk`, `mem_di`, `busy` and `done` are all 0.
- R12: A request with `req_op`=7 is ignored: no frame starts and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_op | input | 3 | Operation code (see R1) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data for write and write-all |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Last word read |
| timed_out | output | 1 | Poll limit reached; valid with done |
| mem_cs | output | 1 | Chip select to the memory |
| mem_sk | output | 1 | Serial clock to the memory |
| mem_di | output | 1 | Serial data to the memory |
| mem_do | input | 1 | Serial data from the memory |

## Verification
Requests are drawn at random over all seven operations, with random addresses, write words, read words and poll counts. Every frame is compared bit for bit with a frame built in the bench, which separates errors in opcode placement, pad count and address alignment. Read words of all ones, a single low bit and alternating bits tell apart a shift in bit order from a sample taken one phase early or late. The number of busy polls is set to 0, to one below the limit and to the limit or above, which separates the last successful poll from a timeout. A second request during a busy read and a reserved opcode show whether stray strobes start a frame.

// File: rtl/eeprom_cmd_seq.sv
module eeprom_cmd_seq #(
  parameter int ADDR_W     = 6,
  parameter bit PAD_EN     = 1'b1,
  parameter int HALF_CYC   = 25,
  parameter int SETUP_CYC  = 10,
  parameter int DESEL_CYC  = 10,
  parameter int POLL_LIMIT = 20000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [15:0]       rd_data,
  output logic              timed_out,
  output logic              mem_cs,
  output logic              mem_sk,
  output logic              mem_di,
  input  logic              mem_do
);
  localparam int CMD_W = 3 + ADDR_W;
  localparam int PAD_W = PAD_EN ? (16 - CMD_W % 16) % 16 : 0;
  localparam int HDR_W = PAD_W + CMD_W;
  localparam int FR_W  = HDR_W + 16;
  localparam int T_A   = HALF_CYC > SETUP_CYC ? HALF_CYC : SETUP_CYC;
  localparam int T_MAX = T_A > DESEL_CYC ? T_A : DESEL_CYC;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam int NW    = $clog2(FR_W + 1);
  localparam int PW    = $clog2(POLL_LIMIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_HIGH, S_LOW, S_GAP, S_CHECK} st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [NW-1:0]  nclk;
  logic [FR_W-1:0] sr;
  logic [15:0]    rsh;
  logic [PW-1:0]  pcnt;
  logic           is_rd, is_wr, fin, tmo;

  logic [FR_W-1:0]   ld_sr;
  logic [NW-1:0]     ld_n;
  logic              ld_rd, ld_wr, ld_ok;
  logic [1:0]        opc, sub;
  logic [ADDR_W-1:0] af;
  logic              dat;

  always_comb begin
    opc = 2'b00; sub = 2'b00; dat = 1'b0;
    ld_rd = 1'b0; ld_wr = 1'b0; ld_ok = 1'b1;
    ld_n = NW'(HDR_W);
    case (req_op)
      3'd0: begin opc = 2'b10; ld_rd = 1'b1; ld_n = NW'(FR_W); end
      3'd1: begin opc = 2'b01; dat = 1'b1; ld_wr = 1'b1; ld_n = NW'(FR_W); end
      3'd2: begin opc = 2'b11; ld_wr = 1'b1; end
      3'd3: begin sub = 2'b01; dat = 1'b1; ld_wr = 1'b1; ld_n = NW'(FR_W); end
      3'd4: begin sub = 2'b10; ld_wr = 1'b1; end
      3'd5: sub = 2'b11;
      3'd6: sub = 2'b00;
      default: ld_ok = 1'b0;
    endcase
    if (opc == 2'b00) begin
      af = '0;
      af[ADDR_W-1 -: 2] = sub;
    end else begin
      af = req_addr;
    end
    ld_sr = '0;
    ld_sr[FR_W-1-PAD_W] = 1'b1;
    ld_sr[FR_W-2-PAD_W -: 2] = opc;
    ld_sr[FR_W-4-PAD_W -: ADDR_W] = af;
    if (dat) ld_sr[15:0] = req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; tmr <= '0; nclk <= '0; sr <= '0; rsh <= '0; pcnt <= '0;
      is_rd <= 1'b0; is_wr <= 1'b0; fin <= 1'b0; tmo <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid && ld_ok) begin
            st <= S_SETUP; tmr <= TW'(SETUP_CYC - 1);
            sr <= ld_sr; nclk <= ld_n; is_rd <= ld_rd; is_wr <= ld_wr;
            fin <= 1'b0; tmo <= 1'b0; pcnt <= '0;
          end
        S_SETUP:
          if (tmr == '0) begin st <= S_HIGH; tmr <= TW'(HALF_CYC - 1); end
          else tmr <= tmr - 1'b1;
        S_HIGH:
          if (tmr == '0) begin
            st <= S_LOW; tmr <= TW'(HALF_CYC - 1); sr <= sr << 1;
          end else tmr <= tmr - 1'b1;
        S_LOW:
          if (tmr == '0) begin
            if (is_rd && nclk <= NW'(16)) rsh <= {rsh[14:0], mem_do};
            if (nclk == NW'(1)) begin
              st <= S_GAP; tmr <= TW'(DESEL_CYC - 1);
            end else begin
              st <= S_HIGH; tmr <= TW'(HALF_CYC - 1); nclk <= nclk - 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        S_GAP:
          if (tmr == '0) begin
            if (is_wr && !fin) begin
              st <= S_CHECK; tmr <= TW'(SETUP_CYC - 1);
            end else begin
              st <= S_IDLE; done <= 1'b1;
            end
          end else tmr <= tmr - 1'b1;
        S_CHECK:
          if (tmr == '0) begin
            st <= S_GAP; tmr <= TW'(DESEL_CYC - 1);
            if (mem_do) fin <= 1'b1;
            else if (pcnt == PW'(POLL_LIMIT - 1)) begin fin <= 1'b1; tmo <= 1'b1; end
            else pcnt <= pcnt + 1'b1;
          end else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_cs    = (st == S_SETUP) || (st == S_HIGH) || (st == S_LOW) || (st == S_CHECK);
  assign mem_sk    = (st == S_HIGH);
  assign mem_di    = ((st == S_SETUP) || (st == S_HIGH) || (st == S_LOW)) && sr[FR_W-1];
  assign rd_data   = rsh;
  assign timed_out = tmo;

  int hi_run, cs_hi_run, cs_lo_run;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_run <= 0; cs_hi_run <= 0; cs_lo_run <= DESEL_CYC;
    end else begin
      hi_run    <= mem_sk ? hi_run + 1 : 0;
      cs_hi_run <= !mem_cs ? 0 : (cs_hi_run < SETUP_CYC ? cs_hi_run + 1 : cs_hi_run);
      cs_lo_run <= mem_cs ? 0 : (cs_lo_run < DESEL_CYC ? cs_lo_run + 1 : cs_lo_run);
    end
  end

  p_sk_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n) mem_sk |-> mem_cs);
  p_sk_high_len_r3: assert property (@(posedge clk) disable iff (!rst_n) $fell(mem_sk) |-> hi_run == HALF_CYC);
  p_di_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n) mem_sk |-> $stable(mem_di));
  p_cs_setup_r4: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_sk) |-> cs_hi_run >= SETUP_CYC);
  p_cs_gap_r5: assert property (@(posedge clk) disable iff (!rst_n) $rose(mem_cs) |-> cs_lo_run >= DESEL_CYC);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  p_done_cs_low_r7: assert property (@(posedge clk) disable iff (!rst_n) done |-> !mem_cs && !busy);
  p_reserved_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid && req_op == 3'd7) |=> !busy);
endmodule

// File: tb/sim_eeprom_cmd_seq.sv
module sim_eeprom_cmd_seq;
  localparam int HALF = 2, SETUP = 3, DESEL = 4, PLIM = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [5:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic busy, done, timed_out, mem_cs, mem_sk, mem_di;
  logic mem_do = 1'b0;
  logic [15:0] rd_data;

  eeprom_cmd_seq #(.ADDR_W(6), .PAD_EN(1'b1), .HALF_CYC(HALF), .SETUP_CYC(SETUP),
                   .DESEL_CYC(DESEL), .POLL_LIMIT(PLIM)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
    .req_wdata(req_wdata), .busy(busy), .done(done), .rd_data(rd_data), .timed_out(timed_out),
    .mem_cs(mem_cs), .mem_sk(mem_sk), .mem_di(mem_di), .mem_do(mem_do));

  always #4 clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  // memory model and line monitor
  bit cur_read = 0;
  logic [15:0] dev_word = '0;
  int poll_left = 0, frame_idx = 0, frames_total = 0;
  logic [31:0] cap = '0, cmd_cap = '0;
  int rises = 0, cmd_rises = 0;
  logic cs_p = 0, sk_p = 0;
  int cs_hi = 0, hi_run = 0, lo_run = 0, gap = 0;
  int setup_min = 1000, gap_min = 1000, phase_bad = 0, sk_out = 0;
  bit seen_frame = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_sk && !mem_cs) sk_out++;
      if (mem_cs && !cs_p) begin
        rises = 0; cap = '0; cs_hi = 0; lo_run = 0;
        if (seen_frame && gap < gap_min) gap_min = gap;
        if (frame_idx >= 1) begin
          mem_do = (poll_left == 0);
          if (poll_left > 0) poll_left--;
        end
      end
      if (mem_sk && !sk_p) begin
        if (rises == 0) begin
          if (cs_hi < setup_min) setup_min = cs_hi;
        end else if (lo_run != HALF) phase_bad++;
        rises++;
        cap = {cap[30:0], mem_di};
        if (cur_read && frame_idx == 0 && rises >= 17) mem_do = dev_word[15 - (rises - 17)];
      end
      if (!mem_sk && sk_p && hi_run != HALF) phase_bad++;
      hi_run = mem_sk ? hi_run + 1 : 0;
      lo_run = (mem_cs && !mem_sk) ? lo_run + 1 : 0;
      if (mem_cs) cs_hi++;
      if (!mem_cs && cs_p) begin
        if (frame_idx == 0) begin cmd_cap = cap; cmd_rises = rises; end
        frame_idx++; frames_total++; mem_do = 1'b0; gap = 0; seen_frame = 1;
      end
      if (!mem_cs) gap++;
      cs_p = mem_cs; sk_p = mem_sk;
    end
  end

  function automatic logic [31:0] exp_frame(input int op, input logic [5:0] a, input logic [15:0] wd);
    logic [1:0] oc; logic [5:0] f; logic [15:0] hdr; logic [15:0] d;
    oc = 2'b00; f = a; d = 16'h0;
    case (op)
      0: oc = 2'b10;
      1: begin oc = 2'b01; d = wd; end
      2: oc = 2'b11;
      3: begin f = 6'b010000; d = wd; end
      4: f = 6'b100000;
      5: f = 6'b110000;
      default: f = 6'b000000;
    endcase
    hdr = {7'b0, 1'b1, oc, f};
    return (op == 0 || op == 1 || op == 3) ? {hdr, d} : {16'h0, hdr};
  endfunction

  function automatic int exp_len(input int op);
    return (op == 0 || op == 1 || op == 3) ? 32 : 16;
  endfunction

  function automatic bit is_prog(input int op);
    return op >= 1 && op <= 4;
  endfunction

  task automatic do_req(input int op, input logic [5:0] a, input logic [15:0] wd,
                        input logic [15:0] dw, input int ra, input bit poke);
    int n, ep;
    bit et;
    cur_read = (op == 0); dev_word = dw; poll_left = ra; frame_idx = 0;
    @(negedge clk);
    req_valid = 1'b1; req_op = 3'(op); req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy == 1'b1, "R7", "busy after accept", busy, 1);
    n = 0;
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      if (poke && n == 20) begin req_valid = 1'b1; req_op = 3'd1; end
      if (poke && n == 22) req_valid = 1'b0;
    end
    chk(done == 1'b1, "R7", "done seen", done, 1);
    chk(mem_cs == 1'b0, "R7", "cs low at done", mem_cs, 0);
    chk(cmd_rises == exp_len(op), "R1", "frame clock count", cmd_rises, exp_len(op));
    chk(cmd_cap == exp_frame(op, a, wd), (op == 0) ? "R2" : "R1", "frame bits",
        cmd_cap, exp_frame(op, a, wd));
    ep = is_prog(op) ? (ra < PLIM ? ra + 1 : PLIM) : 0;
    et = is_prog(op) && ra >= PLIM;
    chk(frame_idx - 1 == ep, is_prog(op) ? (et ? "R9" : "R8") : "R10", "poll count", frame_idx - 1, ep);
    chk(timed_out == et, et ? "R9" : "R8", "timeout flag", timed_out, et);
    if (op == 0) chk(rd_data == dw, "R6", "read word", rd_data, dw);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R7", "done one cycle", {done, busy}, 0);
    if (poke) begin
      repeat (30) begin
        @(negedge clk);
        if (busy || mem_cs) n = -1;
      end
      chk(n != -1, "R7", "request while busy ignored", n == -1, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int f0, bz;
    void'($urandom(32'd20517));
    repeat (3) @(negedge clk);
    chk({mem_cs, mem_sk, mem_di, busy, done} == 5'b0, "R11", "reset outputs",
        {mem_cs, mem_sk, mem_di, busy, done}, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);

    do_req(0, 6'h2A, 16'h0, 16'hA5A5, 0, 0);
    do_req(0, 6'h3F, 16'h0, 16'hFFFF, 0, 0);
    do_req(0, 6'h00, 16'h0, 16'hFFFE, 0, 0);
    do_req(1, 6'h15, 16'h8001, 16'h0, 0, 0);
    do_req(1, 6'h01, 16'h1234, 16'h0, PLIM - 1, 0);
    do_req(2, 6'h20, 16'h0, 16'h0, PLIM, 0);
    do_req(3, 6'h00, 16'hC3C3, 16'h0, 1, 0);
    do_req(4, 6'h00, 16'h0, 16'h0, PLIM + 1, 0);
    do_req(5, 6'h00, 16'h0, 16'h0, 3, 0);
    do_req(6, 6'h00, 16'h0, 16'h0, 0, 0);
    do_req(0, 6'h11, 16'h0, 16'h5A5A, 0, 1);

    // R12: reserved opcode
    f0 = frames_total; bz = 0;
    @(negedge clk); req_valid = 1'b1; req_op = 3'd7;
    @(negedge clk); req_valid = 1'b0;
    repeat (20) begin @(negedge clk); if (busy) bz = 1; end
    chk(bz == 0 && frames_total == f0, "R12", "reserved op ignored", frames_total - f0 + bz, 0);

    for (int i = 0; i < 40; i++) begin
      do_req(int'($urandom % 7), 6'($urandom), 16'($urandom), 16'($urandom),
             int'($urandom % 7), 1'b0);
    end

    chk(phase_bad == 0, "R3", "clock phase widths", phase_bad, 0);
    chk(sk_out == 0, "R3", "clock outside select", sk_out, 0);
    chk(setup_min >= SETUP, "R4", "select setup", setup_min, SETUP);
    chk(gap_min >= DESEL, "R5", "deselect gap", gap_min, DESEL);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule